// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block is a data cache controller placed between a processor load/store port and a slower next-level memory. Each set holds two lines, and the tags of both lines are compared at the same time. Stores stay in the cache until their line is evicted. A store that misses allocates its line. Each set has one recency bit, and that bit picks the line to replace. On the memory side the block moves whole lines. It uses a request/acknowledge pair for both refills and writebacks.

A processor access is taken when `cpu_req` is high in a cycle where `cpu_ready` is high. Every access then gives a one-cycle `cpu_done` pulse, with read data when the access is a load. A hit needs two cycles.

A load miss keeps `cpu_ready` low until the refilled line is written into the cache, and `cpu_done` returns the requested word. A store miss signals `cpu_done` as early as a store hit. The refill then continues in the background, and the controller takes no new access until the refill ends. After the refill the stored word is merged into the line and the line is marked dirty.

Top module: `wb_dcache`

## Requirements
- R1: With the default 40-bit address, bits [39:15] are the tag, bits [14:6] the set index and bits [5:3] select one 64-bit word of the eight in a line; bits [2:0] have no effect on the access.
- R2: A load that hits is taken in cycle c and raises `cpu_done` with the addressed word in cycle c+2, for exactly one cycle.
- R3: A store that hits replaces only the addressed word, produces no next-level request, and a later load of that word returns the stored value.
- R4: Two lines with the same set index and different tags can be resident together; after both are filled, accesses to either one hit.
- R5: On a miss the victim is the way named by the set's recency bit; every hit and every fill makes the other way the next victim.
- R6: A valid dirty victim is written back as a full line (`mem_we`=1, its own line address) before the refill request; a clean or invalid victim causes no writeback.
- R7: During a load miss `cpu_ready` stays low until the refill acknowledge, after which `cpu_done` returns the addressed word of the refilled line.
- R8: A store miss raises `cpu_done` in cycle c+2, before its refill completes, with `cpu_ready` low; after the refill the line holds the stored word among refilled data and is dirty.
- R9: After reset `cpu_ready` is high and every line is invalid and clean, so the first access to any line misses and no writeback is issued.
- R10: `mem_req` stays high with stable `mem_addr` and `mem_we` until `mem_ack`; every `mem_addr` has its six line-offset bits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 40 | Byte address of the access |
| cpu_wdata | input | 64 | Store word |
| cpu_ready | output | 1 | Controller can take an access this cycle |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 64 | Load word, valid with `cpu_done` |
| mem_req | output | 1 | Next-level line request |
| mem_we | output | 1 | 1 = writeback, 0 = refill |
| mem_addr | output | 40 | Line-aligned next-level address |
| mem_wline | output | 512 | Line data for a writeback |
| mem_ack | input | 1 | Next-level acknowledge, one cycle |
| mem_rline | input | 512 | Refill line, valid with `mem_ack` |

## Verification
The tests follow the recency bit through one set across several fills and hits. A controller with the recency update wrong would evict the line that was just used, and a dirty line would then be written back at the wrong time. One dirty eviction is checked for order and content: the writeback must come before the refill and must carry the earlier store. A controller that skipped the writeback, or sent it after the refill, would lose the store, and a later reload would return stale data. The store miss is checked in the cycle of its early completion, when `cpu_ready` must still be low and the refill must not yet be done. A controller that stalled the store, or merged the word into the wrong place, would fail this test. A reset after a store checks that the dirty line is neither flushed nor kept.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_WBACK = 2'd2,
    ST_FILL  = 2'd3
  } dc_state_t;
endpackage

// File: rtl/dc_sram.sv
module dc_sram #(
  parameter int W     = 64,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  dout
);
  logic [W-1:0] mem [DEPTH];

  // single write port, registered read port: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= din;
    dout <= mem[raddr];
  end
endmodule

// File: rtl/dc_meta.sv
module dc_meta #(
  parameter int SETS = 512,
  localparam int IW  = $clog2(SETS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] idx,
  input  logic          upd_en,
  input  logic          upd_way,
  input  logic          upd_dirty,
  input  logic          lru_en,
  input  logic          lru_val,
  output logic [1:0]    valid_o,
  output logic [1:0]    dirty_o,
  output logic          lru_o
);
  logic [SETS-1:0] vld [2];
  logic [SETS-1:0] drt [2];
  logic [SETS-1:0] lru;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld[0] <= '0;
      vld[1] <= '0;
      drt[0] <= '0;
      drt[1] <= '0;
      lru    <= '0;
    end else begin
      if (upd_en) begin
        vld[upd_way][idx] <= 1'b1;
        drt[upd_way][idx] <= upd_dirty;
      end
      if (lru_en) lru[idx] <= lru_val;
    end
  end

  assign valid_o = {vld[1][idx], vld[0][idx]};
  assign dirty_o = {drt[1][idx], drt[0][idx]};
  assign lru_o   = lru[idx];

  // a dirty line is always a valid line (R6)
  assert_dirty_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (dirty_o[0] |-> valid_o[0]) and (dirty_o[1] |-> valid_o[1]));
endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
  import dc_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int SETS       = 512,
  parameter int LINE_BYTES = 64,
  parameter int WORD_W     = 64,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int WORDS  = LINE_W / WORD_W,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int BOFF_W = $clog2(WORD_W / 8),
  localparam int WSEL_W = OFF_W - BOFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_done,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wline,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rline
);
  dc_state_t state;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_wsel;
  logic              req_we;
  logic [WORD_W-1:0] req_wdata;
  logic              vic_way;

  logic [TAG_W-1:0]  cpu_tag;
  logic [IDX_W-1:0]  cpu_idx;
  logic [WSEL_W-1:0] cpu_wsel;
  logic              unused_byte_bits;
  assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  assign cpu_idx  = cpu_addr[OFF_W +: IDX_W];
  assign cpu_wsel = cpu_addr[BOFF_W +: WSEL_W];
  assign unused_byte_bits = ^cpu_addr[BOFF_W-1:0];

  logic [IDX_W-1:0]  rd_idx;
  assign rd_idx = (state == ST_IDLE) ? cpu_idx : req_idx;

  logic [TAG_W-1:0]  tag_q  [2];
  logic [WORD_W-1:0] word_q [2][WORDS];
  logic [1:0]        valid_q, dirty_q, hit_v;
  logic              lru_q, hit, hit_way, fill_now, store_hit;

  assign fill_now  = (state == ST_FILL) && mem_ack;
  assign hit_v     = {valid_q[1] && (tag_q[1] == req_tag),
                      valid_q[0] && (tag_q[0] == req_tag)};
  assign hit       = |hit_v;
  assign hit_way   = hit_v[1];
  assign store_hit = (state == ST_LOOK) && hit && req_we;

  // tag and data storage, one RAM per way and per word
  for (genvar w = 0; w < 2; w++) begin : g_way
    logic tag_we;
    assign tag_we = fill_now && (vic_way == w[0]);
    dc_sram #(.W(TAG_W), .DEPTH(SETS)) u_tag (
      .clk(clk), .we(tag_we), .waddr(req_idx), .din(req_tag),
      .raddr(rd_idx), .dout(tag_q[w]));
    for (genvar k = 0; k < WORDS; k++) begin : g_word
      logic              dat_we;
      logic [WORD_W-1:0] dat_din;
      logic              is_sel;
      assign is_sel  = (req_wsel == WSEL_W'(k));
      assign dat_we  = (fill_now && (vic_way == w[0])) ||
                       (store_hit && (hit_way == w[0]) && is_sel);
      assign dat_din = (state == ST_FILL && !(req_we && is_sel)) ?
                       mem_rline[k*WORD_W +: WORD_W] : req_wdata;
      dc_sram #(.W(WORD_W), .DEPTH(SETS)) u_dat (
        .clk(clk), .we(dat_we), .waddr(req_idx), .din(dat_din),
        .raddr(rd_idx), .dout(word_q[w][k]));
    end
  end

  dc_meta #(.SETS(SETS)) u_meta (
    .clk(clk), .rst(rst), .idx(req_idx),
    .upd_en(fill_now || store_hit),
    .upd_way(fill_now ? vic_way : hit_way),
    .upd_dirty(fill_now ? req_we : 1'b1),
    .lru_en(fill_now || (state == ST_LOOK && hit)),
    .lru_val(fill_now ? ~vic_way : ~hit_way),
    .valid_o(valid_q), .dirty_o(dirty_q), .lru_o(lru_q));

  logic [LINE_W-1:0] lru_line;
  always_comb begin
    for (int k = 0; k < WORDS; k++) lru_line[k*WORD_W +: WORD_W] = word_q[lru_q][k];
  end

  assign cpu_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wline <= '0;
      req_tag   <= '0;
      req_idx   <= '0;
      req_wsel  <= '0;
      req_we    <= 1'b0;
      req_wdata <= '0;
      vic_way   <= 1'b0;
    end else begin
      cpu_done <= 1'b0;
      case (state)
        ST_IDLE: if (cpu_req) begin
          req_tag   <= cpu_tag;
          req_idx   <= cpu_idx;
          req_wsel  <= cpu_wsel;
          req_we    <= cpu_we;
          req_wdata <= cpu_wdata;
          state     <= ST_LOOK;
        end
        ST_LOOK: if (hit) begin
          if (!req_we) cpu_rdata <= word_q[hit_way][req_wsel];
          cpu_done <= 1'b1;
          state    <= ST_IDLE;
        end else begin
          vic_way <= lru_q;
          mem_req <= 1'b1;
          if (req_we) cpu_done <= 1'b1;   // store accepted provisionally
          if (valid_q[lru_q] && dirty_q[lru_q]) begin
            mem_we    <= 1'b1;
            mem_addr  <= {tag_q[lru_q], req_idx, {OFF_W{1'b0}}};
            mem_wline <= lru_line;
            state     <= ST_WBACK;
          end else begin
            mem_we   <= 1'b0;
            mem_addr <= {req_tag, req_idx, {OFF_W{1'b0}}};
            state    <= ST_FILL;
          end
        end
        ST_WBACK: if (mem_ack) begin
          mem_we   <= 1'b0;
          mem_addr <= {req_tag, req_idx, {OFF_W{1'b0}}};
          state    <= ST_FILL;
        end
        ST_FILL: if (mem_ack) begin
          mem_req <= 1'b0;
          if (!req_we) begin
            cpu_rdata <= mem_rline[req_wsel*WORD_W +: WORD_W];
            cpu_done  <= 1'b1;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_hit_unique_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOK) |-> $onehot0(hit_v));
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_wb_before_fill_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && mem_we) |=> (mem_req && !mem_we));
  assert_stall_in_miss_R7: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);
endmodule

// File: tb/sim_wb_dcache.sv
`timescale 1ns/1ps
module sim_wb_dcache;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic         cpu_req = 1'b0, cpu_we = 1'b0;
  logic [39:0]  cpu_addr = '0;
  logic [63:0]  cpu_wdata = '0;
  logic         cpu_ready, cpu_done;
  logic [63:0]  cpu_rdata;
  logic         mem_req, mem_we;
  logic [39:0]  mem_addr;
  logic [511:0] mem_wline;
  logic         mem_ack;
  logic [511:0] mem_rline;

  wb_dcache u0 (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  // next-level memory model
  logic [511:0] store [logic [39:0]];
  int  cnt = 0, wb_cnt = 0, fill_cnt = 0, evt = 0, wb_evt = 0, fill_evt = 0, addr_bad = 0;
  logic [39:0]  wb_addr;
  logic [511:0] wb_line;

  function automatic logic [63:0] dflt(input logic [39:0] la, input int i);
    return {la[39:6], 27'h0, i[2:0]};
  endfunction
  function automatic logic [511:0] get_line(input logic [39:0] la);
    logic [511:0] l;
    if (store.exists(la)) return store[la];
    for (int i = 0; i < 8; i++) l[i*64 +: 64] = dflt(la, i);
    return l;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0; cnt = 0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (cnt == 3) begin
          cnt = 0;
          mem_ack <= 1'b1;
          evt++;
          if (mem_addr[5:0] != 6'd0) addr_bad++;
          if (mem_we) begin
            store[mem_addr] = mem_wline;
            wb_cnt++; wb_evt = evt; wb_addr = mem_addr; wb_line = mem_wline;
          end else begin
            mem_rline <= get_line(mem_addr);
            fill_cnt++; fill_evt = evt;
          end
        end else cnt++;
      end else cnt = 0;
    end
  end

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] mk(input logic [24:0] t, input logic [8:0] s,
                                     input logic [2:0] w, input logic [2:0] b);
    return {t, s, w, b};
  endfunction
  function automatic logic [39:0] ln(input logic [39:0] a);
    return {a[39:6], 6'd0};
  endfunction

  // one access; returns data, latency in cycles and whether ready rose early
  task automatic acc(input logic we, input logic [39:0] a, input logic [63:0] wd,
                     output logic [63:0] rd, output int lat, output bit rdy);
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    lat = 0; rdy = 0; rd = '0;
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk);
      if (k == 1) cpu_req = 1'b0;
      if (cpu_done) begin lat = k; rd = cpu_rdata; break; end
      if (cpu_ready) rdy = 1;
    end
  endtask

  task automatic wait_ready();
    while (!cpu_ready) @(negedge clk);
  endtask

  localparam logic [8:0]  S  = 9'h0A5, T = 9'h13C;
  localparam logic [24:0] TA = 25'h1, TB = 25'h2, TC = 25'h3, TD = 25'h4, TE = 25'h5, TF = 25'h6;
  localparam logic [63:0] XV = 64'hDEAD_BEEF_0123_4567, YV = 64'hFACE_CAFE_89AB_CDEF;

  task automatic t_reset_first_miss();
    logic [63:0] d; int lat; bit r;
    chk("R9 ready after reset", cpu_ready, 1);
    acc(0, mk(TA, S, 2, 0), 0, d, lat, r);
    chk("R9 first access misses", lat > 2, 1);
    chk("R7 load miss data", d, dflt(ln(mk(TA, S, 0, 0)), 2));
    chk("R7 ready low during load miss", r, 0);
    chk("R9 no writeback on first miss", wb_cnt, 0);
  endtask

  task automatic t_load_hit();
    logic [63:0] d; int lat; bit r;
    acc(0, mk(TA, S, 2, 3'b101), 0, d, lat, r);
    chk("R2 load hit latency", lat, 2);
    chk("R1 byte bits ignored", d, dflt(ln(mk(TA, S, 0, 0)), 2));
    acc(0, mk(TA, S, 7, 0), 0, d, lat, r);
    chk("R1 word select", d, dflt(ln(mk(TA, S, 0, 0)), 7));
    @(negedge clk);
    chk("R2 done one cycle", cpu_done, 0);
  endtask

  task automatic t_store_hit();
    logic [63:0] d; int lat; bit r; int f0, w0;
    f0 = fill_cnt; w0 = wb_cnt;
    acc(1, mk(TA, S, 3, 0), XV, d, lat, r);
    chk("R3 store hit latency", lat, 2);
    repeat (6) @(negedge clk);
    chk("R3 no next-level traffic", (fill_cnt - f0) + (wb_cnt - w0), 0);
    acc(0, mk(TA, S, 3, 0), 0, d, lat, r);
    chk("R3 store visible", d, XV);
    acc(0, mk(TA, S, 4, 0), 0, d, lat, r);
    chk("R3 neighbour word kept", d, dflt(ln(mk(TA, S, 0, 0)), 4));
  endtask

  task automatic t_two_way_lru();
    logic [63:0] d; int lat; bit r; int w0;
    acc(0, mk(TB, S, 0, 0), 0, d, lat, r);
    chk("R4 second tag misses", lat > 2, 1);
    chk("R4 no writeback into free way", wb_cnt, 0);
    acc(0, mk(TA, S, 3, 0), 0, d, lat, r);
    chk("R4 first line still hits", lat, 2);
    acc(0, mk(TB, S, 0, 0), 0, d, lat, r);
    chk("R4 second line hits", lat, 2);
    acc(0, mk(TA, S, 0, 0), 0, d, lat, r);  // A becomes most recent
    w0 = wb_cnt;
    acc(0, mk(TC, S, 1, 0), 0, d, lat, r);
    chk("R5 clean LRU victim no writeback", wb_cnt, w0);
    acc(0, mk(TA, S, 3, 0), 0, d, lat, r);
    chk("R5 recently used line kept", lat, 2);
    acc(0, mk(TB, S, 0, 0), 0, d, lat, r);  // victim is C
    chk("R5 evicted line misses", lat > 2, 1);
    chk("R6 clean victim C no writeback", wb_cnt, w0);
    acc(0, mk(TC, S, 0, 0), 0, d, lat, r);  // victim is dirty A
    chk("R6 dirty victim written back", wb_cnt, w0 + 1);
    chk("R6 writeback address", wb_addr, ln(mk(TA, S, 0, 0)));
    chk("R6 writeback holds store", wb_line[3*64 +: 64], XV);
    chk("R6 writeback other word", wb_line[0 +: 64], dflt(ln(mk(TA, S, 0, 0)), 0));
    chk("R6 writeback before refill", wb_evt < fill_evt, 1);
    chk("R7 data after dirty eviction", d, dflt(ln(mk(TC, S, 0, 0)), 0));
    acc(0, mk(TA, S, 3, 0), 0, d, lat, r);
    chk("R6 evicted store survives", d, XV);
  endtask

  task automatic t_store_miss();
    logic [63:0] d; int lat; bit r; int f0, w0;
    f0 = fill_cnt;
    acc(1, mk(TD, T, 5, 0), YV, d, lat, r);
    chk("R8 store miss early done", lat, 2);
    chk("R8 ready low after early done", cpu_ready, 0);
    chk("R8 refill still pending", fill_cnt, f0);
    wait_ready();
    chk("R8 refill done", fill_cnt, f0 + 1);
    acc(0, mk(TD, T, 5, 0), 0, d, lat, r);
    chk("R8 merged word hits", lat, 2);
    chk("R8 merged word value", d, YV);
    acc(0, mk(TD, T, 2, 0), 0, d, lat, r);
    chk("R8 refilled word value", d, dflt(ln(mk(TD, T, 0, 0)), 2));
    w0 = wb_cnt;
    acc(0, mk(TE, T, 0, 0), 0, d, lat, r);
    acc(0, mk(TF, T, 0, 0), 0, d, lat, r);
    chk("R8 store-miss line dirty", wb_cnt, w0 + 1);
    chk("R8 writeback carries store", wb_line[5*64 +: 64], YV);
  endtask

  task automatic t_reset_drops();
    logic [63:0] d; int lat; bit r; int w0;
    acc(1, mk(TF, T, 1, 0), 64'h1234, d, lat, r);
    w0 = wb_cnt;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 ready after mid reset", cpu_ready, 1);
    acc(0, mk(TF, T, 1, 0), 0, d, lat, r);
    chk("R9 line invalid after reset", lat > 2, 1);
    chk("R9 no writeback at reset", wb_cnt, w0);
    chk("R9 dirty data dropped", d, dflt(ln(mk(TF, T, 0, 0)), 1));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_first_miss();
    t_load_hit();
    t_store_hit();
    t_two_way_lru();
    t_store_miss();
    t_reset_drops();
    chk("R10 line-aligned next-level address", addr_bad, 0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end
endmodule